// File: doc/BRIEF.md
# Peripheral Reset Pulse Controller

A memory-mapped block that lets software hold a chosen set of peripheral reset lines in reset for a programmed time. Software first writes a selection mask into a register of the configuration region, then writes a trigger register in a second region with a start bit and a duration field. The block copies the selected lines at the moment it starts, holds them in reset for a whole number of prescaled time units, and then releases them. It clears the start bit by itself, so software can poll that bit to learn that the pulse is over.

The configuration region also holds three neighbouring control registers that are only stored and read back. Accesses use a simple single-cycle request port. Read data returns one cycle after the request.

Top module: `periph_rst_pulser`

## Requirements
- R1: A synchronous power-on reset (`rst` high) clears every register to 0 and deasserts every `periphRst` output.
- R2: The selection register sits at offset 0x20 of the configuration region (`reqRegion`=0). Only bits 16, 17, 18, 19, 20, 21, 22, 25 and 31 are stored. All other bits read as 0.
- R3: The configuration registers at offsets 0x00, 0x40 and 0x60 store all 32 written bits and read them back unchanged.
- R4: The trigger register sits at offset 0x0 of the trigger region (`reqRegion`=1). Bits 31:16 read back the last duration value written. Bit 0 reads 1 while a pulse is active and 0 otherwise. All other bits read as 0.
- R5: Writing the trigger register with bit 0 set while no pulse is active starts a pulse. From the clock edge that takes the write, `periphRst` equals the captured selection lines for exactly (duration+1)×PRESCALE cycles. After that it returns to all zeros and bit 0 reads 0.
- R6: A duration of 0 gives the shortest pulse, PRESCALE cycles (16 with the default).
- R7: The selection mask is captured when the pulse starts. Writing the selection register during a pulse does not change `periphRst` until the next pulse.
- R8: A trigger write with bit 0 set during an active pulse neither restarts nor lengthens the pulse. A trigger write with bit 0 clear starts no pulse. Either write still updates the stored duration.
- R9: The lines map to `periphRst` indices in this order: index 0 ← bit 16, 1 ← bit 17, 2 ← bit 18, 3 ← bit 19, 4 ← bit 20, 5 ← bit 21, 6 ← bit 22, 7 ← bit 25, 8 ← bit 31.
- R10: Read data and `rspValid` appear on the cycle after a read request. A write request gives no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRegion | input | 1 | 0 = configuration region, 1 = trigger region |
| reqAddr | input | ADDR_W (7) | Byte offset within the region |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read data valid, one cycle after a read |
| rspRdata | output | 32 | Read data |
| periphRst | output | 9 | Per-line peripheral reset, active high |

## Verification
Every read result is due on the cycle after its request. A read task queues the expected word when it issues the request, and a monitor compares the word at the falling edge on which `rspValid` is high. A pulse shows on `periphRst` right after the edge that takes the start write. The bench therefore begins counting at the first falling edge after that write, and checks both the line pattern and the exact number of cycles the pulse lasts. For writes made during a pulse, the count of remaining cycles subtracts the cycles those writes used, so a restart or a change of mask would show as a wrong length or a wrong pattern.

// File: rtl/prst_pkg.sv
package prst_pkg;
  localparam int NUM_LINES = 9;
  localparam int DATA_W = 32;
  localparam int DELAY_W = 16;
  localparam int DELAY_LSB = 16;

  // selection-register bit that drives reset line idx
  function automatic int lineBitPos(input int idx);
    case (idx)
      0: return 16;
      1: return 17;
      2: return 18;
      3: return 19;
      4: return 20;
      5: return 21;
      6: return 22;
      7: return 25;
      8: return 31;
      default: return 16;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] selValidMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_LINES; k++) m[lineBitPos(k)] = 1'b1;
    return m;
  endfunction

  typedef struct packed {
    logic captureSel;
    logic pulseOn;
  } ctrlStb_t;
endpackage

// File: rtl/prst_datapath.sv
module prst_datapath
  import prst_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqRegion,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  ctrlStb_t             stb,
  output logic                 rspValid,
  output logic [DATA_W-1:0]    rspRdata,
  output logic                 trigStart,
  output logic [DELAY_W-1:0]   delayIn,
  output logic [NUM_LINES-1:0] periphRst
);
  localparam int IDX_W = ADDR_W - 5;
  localparam int CFG_N = 2 ** IDX_W;
  localparam int SEL_IDX = 1;  // offset 0x20
  localparam logic [DATA_W-1:0] SEL_MASK = selValidMask();

  logic [DATA_W-1:0]  cfgReg [CFG_N];
  logic [DELAY_W-1:0] delayReg;
  logic [NUM_LINES-1:0] heldMask;
  logic [DATA_W-1:0]  readMux;
  logic [IDX_W-1:0]   cfgIdx;
  logic cfgHit, trigHit;

  assign cfgIdx  = reqAddr[ADDR_W-1:5];
  assign cfgHit  = reqValid & ~reqRegion & (reqAddr[4:0] == 5'd0);
  assign trigHit = reqValid & reqRegion & (reqAddr == '0);

  assign trigStart = trigHit & reqWrite & reqWdata[0];
  assign delayIn   = reqWdata[DELAY_LSB +: DELAY_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < CFG_N; k++) cfgReg[k] <= '0;
      delayReg <= '0;
    end else begin
      if (cfgHit && reqWrite) begin
        if (cfgIdx == IDX_W'(SEL_IDX)) cfgReg[cfgIdx] <= reqWdata & SEL_MASK;
        else cfgReg[cfgIdx] <= reqWdata;
      end
      if (trigHit && reqWrite) delayReg <= reqWdata[DELAY_LSB +: DELAY_W];
    end
  end

  always_comb begin
    readMux = '0;
    if (cfgHit) readMux = cfgReg[cfgIdx];
    else if (trigHit) begin
      readMux[DELAY_LSB +: DELAY_W] = delayReg;
      readMux[0] = stb.pulseOn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= reqValid & ~reqWrite;
      rspRdata <= (reqValid & ~reqWrite) ? readMux : '0;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    localparam int POS = lineBitPos(i);
    always_ff @(posedge clk) begin
      if (rst) heldMask[i] <= 1'b0;
      else if (stb.captureSel) heldMask[i] <= cfgReg[SEL_IDX][POS];
    end
    assign periphRst[i] = stb.pulseOn & heldMask[i];
  end
endmodule

// File: rtl/prst_control.sv
module prst_control
  import prst_pkg::*;
#(
  parameter int PRESCALE = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trigStart,
  input  logic [DELAY_W-1:0] delayIn,
  output ctrlStb_t           stb
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic busy;
  logic [PRE_W-1:0]   preCnt;
  logic [DELAY_W-1:0] unitCnt;
  logic startNow;

  assign startNow = trigStart & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      preCnt  <= '0;
      unitCnt <= '0;
    end else if (startNow) begin
      busy    <= 1'b1;
      preCnt  <= '0;
      unitCnt <= delayIn;
    end else if (busy) begin
      if (preCnt == PRE_LAST) begin
        preCnt <= '0;
        if (unitCnt == '0) busy <= 1'b0;
        else unitCnt <= unitCnt - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.captureSel = startNow;
    stb.pulseOn    = busy;
  end
endmodule

// File: rtl/periph_rst_pulser.sv
module periph_rst_pulser
  import prst_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int PRESCALE = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqRegion,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 rspValid,
  output logic [DATA_W-1:0]    rspRdata,
  output logic [NUM_LINES-1:0] periphRst
);
  ctrlStb_t stb;
  logic trigStart;
  logic [DELAY_W-1:0] delayIn;

  prst_control #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rst(rst), .trigStart(trigStart), .delayIn(delayIn), .stb(stb)
  );

  prst_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRegion(reqRegion), .reqAddr(reqAddr), .reqWdata(reqWdata), .stb(stb),
    .rspValid(rspValid), .rspRdata(rspRdata), .trigStart(trigStart),
    .delayIn(delayIn), .periphRst(periphRst)
  );
endmodule

// File: rtl/prst_checker.sv
module prst_checker
  import prst_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 reqValid,
  input logic                 reqWrite,
  input logic                 rspValid,
  input logic                 pulseOn,
  input logic                 captureSel,
  input logic [NUM_LINES-1:0] periphRst
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (periphRst == '0));

  a_r5_lines_only_in_pulse: assert property (@(posedge clk) disable iff (rst)
    (periphRst != '0) |-> pulseOn);

  a_r5_start_opens_pulse: assert property (@(posedge clk) disable iff (rst)
    captureSel |=> pulseOn);

  a_r7_lines_frozen: assert property (@(posedge clk) disable iff (rst)
    (pulseOn && $past(pulseOn)) |-> $stable(periphRst));

  a_r8_pulse_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(pulseOn) |-> $past(captureSel));

  a_r10_read_response: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqWrite) |=> rspValid);
endmodule

bind periph_rst_pulser prst_checker u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
  .rspValid(rspValid), .pulseOn(stb.pulseOn), .captureSel(stb.captureSel),
  .periphRst(periphRst)
);

// File: tb/periph_rst_pulser_test.sv
module periph_rst_pulser_test;
  localparam int PRESCALE = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqRegion = 1'b0;
  logic [6:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic rspValid;
  logic [31:0] rspRdata;
  logic [8:0] periphRst;

  int total = 0;
  int bad = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  periph_rst_pulser uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRegion(reqRegion), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .periphRst(periphRst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data when the design answers
  always @(negedge clk) begin
    if (!rst && rspValid) begin
      if (expQ.size() == 0) chk("R10 unexpected response", 32'h1, 32'h0);
      else chk(tagQ.pop_front(), rspRdata, expQ.pop_front());
    end
  end

  task automatic busWrite(input logic region, input logic [6:0] addr, input logic [31:0] data);
    reqValid = 1'b1; reqWrite = 1'b1; reqRegion = region; reqAddr = addr; reqWdata = data;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic busRead(input logic region, input logic [6:0] addr, input logic [31:0] exp,
                         input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    reqValid = 1'b1; reqWrite = 1'b0; reqRegion = region; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // counts pulse cycles from the current falling edge
  task automatic measure(input logic [8:0] expMask, input int expLen, input string tag);
    int cnt = 0;
    int wrong = 0;
    logic [8:0] seen = '0;
    while (periphRst != '0 && cnt < 100000) begin
      if (periphRst !== expMask && wrong == 0) begin wrong = 1; seen = periphRst; end
      cnt++;
      @(negedge clk);
    end
    chk({tag, " lines"}, 32'(wrong ? seen : expMask), 32'(expMask));
    chk({tag, " length"}, 32'(cnt), 32'(expLen));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pos[9] = '{16, 17, 18, 19, 20, 21, 22, 25, 31};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 lines after reset", 32'(periphRst), 32'h0);
    busRead(0, 7'h00, 32'h0, "R1 cfg00");
    busRead(0, 7'h20, 32'h0, "R1 sel");
    busRead(0, 7'h60, 32'h0, "R1 cfg60");
    busRead(1, 7'h00, 32'h0, "R1 trigger");
    // R3 neighbour storage
    busWrite(0, 7'h00, 32'hA5A5_5A5A);
    busWrite(0, 7'h40, 32'hFFFF_FFFF);
    busWrite(0, 7'h60, 32'h1234_5678);
    busRead(0, 7'h00, 32'hA5A5_5A5A, "R3 cfg00");
    busRead(0, 7'h40, 32'hFFFF_FFFF, "R3 cfg40");
    busRead(0, 7'h60, 32'h1234_5678, "R3 cfg60");
    // R2 selection bit filtering
    busWrite(0, 7'h20, 32'hFFFF_FFFF);
    busRead(0, 7'h20, 32'h827F_0000, "R2 sel all ones");
    busWrite(0, 7'h20, 32'h0000_FFFF);
    busRead(0, 7'h20, 32'h0000_0000, "R2 sel low bits");
    // R8 bit0 clear starts nothing, R4 delay read-back
    busWrite(0, 7'h20, 32'h0005_0000);
    busWrite(1, 7'h00, 32'h0003_FFFE);
    repeat (4) @(negedge clk);
    chk("R8 no pulse on bit0=0", 32'(periphRst), 32'h0);
    busRead(1, 7'h00, 32'h0003_0000, "R4 delay readback");
    // R5 pulse length (3+1)*16, lines 0 and 2
    busWrite(1, 7'h00, 32'h0003_0001);
    measure(9'h005, 4 * PRESCALE, "R5 delay3");
    busRead(1, 7'h00, 32'h0003_0000, "R5 busy cleared");
    // R4 busy bit visible during pulse
    busWrite(1, 7'h00, 32'h0002_0001);
    busRead(1, 7'h00, 32'h0002_0001, "R4 busy during pulse");
    repeat (3 * PRESCALE + 4) @(negedge clk);
    busRead(1, 7'h00, 32'h0002_0000, "R4 busy after pulse");
    // R6 minimum pulse
    busWrite(1, 7'h00, 32'h0000_0001);
    measure(9'h005, PRESCALE, "R6 delay0");
    // R7/R8 writes during pulse
    busWrite(0, 7'h20, 32'h8000_0000);
    busWrite(1, 7'h00, 32'h0001_0001);
    busWrite(0, 7'h20, 32'h0200_0000);
    chk("R7 lines kept after sel write", 32'(periphRst), 32'h100);
    busWrite(1, 7'h00, 32'h0007_0001);
    measure(9'h100, 2 * PRESCALE - 2, "R8 no restart");
    busRead(0, 7'h20, 32'h0200_0000, "R7 sel stored");
    busRead(1, 7'h00, 32'h0007_0000, "R8 delay updated");
    busWrite(1, 7'h00, 32'h0000_0001);
    measure(9'h080, PRESCALE, "R7 new mask next pulse");
    // R9 line mapping
    for (int i = 0; i < 9; i++) begin
      busWrite(0, 7'h20, 32'h1 << pos[i]);
      busWrite(1, 7'h00, 32'h0000_0001);
      measure(9'h1 << i, PRESCALE, $sformatf("R9 line%0d", i));
    end
    repeat (4) @(negedge clk);
    chk("R10 responses drained", 32'(expQ.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule